// File: doc/BRIEF.md
# Register File with Special Registers

This block is the architectural register file of a 32-bit processor core. It holds a bank of general registers and four special registers: two auxiliary registers named Rg and Rd, the program counter and a flag word. All of them are reached through a 6-bit register specifier. A fifth special register, the stack pointer, sits beside them with its own load port and output. It comes out of reset pointing at the last word of data memory.

One write port and two combinational read ports serve the specifier space. The four condition flags (overflow, zero, sign, parity) can each be set or cleared by dedicated strobes without disturbing the rest of the flag word, and they are also brought out already decoded. Any enabled access to a general index beyond the implemented bank sets a sticky error bit. Such a read returns zero and such a write is dropped.

Top module: `regbank_spec`

## Requirements
- R1: With specifier bit 5 at 0, bits [4:0] address general register 0 to NUM_GPR-1. A write lands on the clock edge when `wr_en` is high. Both read ports return the addressed register combinationally.
- R2: With specifier bit 5 at 1, bits [1:0] select Rg (0), Rd (1), program counter (2) or flag word (3), and bits [4:2] are ignored. A write to one special register leaves every other register unchanged.
- R3: A general index at or above NUM_GPR is invalid. Reading it returns zero, writing it changes no register, and any such access with its enable high sets `err_q` on the next edge.
- R4: `err_q` is sticky. Once set, it stays at 1 until reset.
- R5: The flag word holds overflow in bit 0, zero in bit 1, sign in bit 2 and parity in bit 3. The outputs `flag_ovf`, `flag_zero`, `flag_sign` and `flag_par` mirror these bits.
- R6: A high bit n in `flag_clr` clears flag bit n, and a high bit n in `flag_set` sets it. The other flag bits are untouched. When set and clear target the same bit, set wins.
- R7: When a port write to the flag word and flag strobes occur in the same cycle, the strobes are applied on top of the written value.
- R8: The stack pointer resets to MEM_WORDS-1 (1023 by default). It takes `sp_wdata` on an edge where `sp_we` is high and is visible on `sp_q`.
- R9: A read in the same cycle as a write to the same register returns the old value. The new value appears after the edge.
- R10: Reset (`rst_n` low, asynchronous) clears all general registers, Rg, Rd, the program counter, the flag word and `err_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the specifier write port |
| wr_sel | input | 6 | Write specifier |
| wr_data | input | 32 | Write data |
| rd_a_en | input | 1 | Marks port A read as a real access (for error detection) |
| rd_a_sel | input | 6 | Port A specifier |
| rd_a_data | output | 32 | Port A read data |
| rd_b_en | input | 1 | Marks port B read as a real access |
| rd_b_sel | input | 6 | Port B specifier |
| rd_b_data | output | 32 | Port B read data |
| flag_set | input | 4 | Per-bit flag set strobes |
| flag_clr | input | 4 | Per-bit flag clear strobes |
| sp_we | input | 1 | Stack pointer load enable |
| sp_wdata | input | 32 | Stack pointer load value |
| sp_q | output | 32 | Stack pointer |
| flag_ovf | output | 1 | Overflow flag (bit 0) |
| flag_zero | output | 1 | Zero flag (bit 1) |
| flag_sign | output | 1 | Sign flag (bit 2) |
| flag_par | output | 1 | Parity flag (bit 3) |
| err_q | output | 1 | Sticky illegal-access error |

## Verification
Two functions can fall in the same cycle. A port write to the flag word can coincide with the flag set and clear strobes, and a read can coincide with a write to the same register. The bench drives a flag-word write of 0x8 together with a set on bit 0 and a clear on bit 3, and expects exactly 0x1. It also applies set and clear to one bit at once and expects the set to win. For the read/write collision it samples the read port before the edge and expects the old value, then samples after the edge and expects the new one.

// File: rtl/regbank_spec.sv
module regbank_spec #(
  parameter int DATA_W    = 32,
  parameter int NUM_GPR   = 32,
  parameter int MEM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_a_en,
  input  logic [5:0]        rd_a_sel,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [5:0]        rd_b_sel,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [3:0]        flag_set,
  input  logic [3:0]        flag_clr,
  input  logic              sp_we,
  input  logic [DATA_W-1:0] sp_wdata,
  output logic [DATA_W-1:0] sp_q,
  output logic              flag_ovf,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_par,
  output logic              err_q
);

  localparam logic [5:0]        GPR_LIMIT = 6'(NUM_GPR);
  localparam logic [DATA_W-1:0] SP_INIT   = DATA_W'(MEM_WORDS - 1);

  logic [DATA_W-1:0] gpr [NUM_GPR];
  logic [DATA_W-1:0] reg_rg, reg_rd, reg_pc, reg_flag, flag_nx;

  logic wr_bad, a_bad, b_bad, wr_spec;

  assign wr_bad  = ~wr_sel[5]   & ({1'b0, wr_sel[4:0]}   >= GPR_LIMIT);
  assign a_bad   = ~rd_a_sel[5] & ({1'b0, rd_a_sel[4:0]} >= GPR_LIMIT);
  assign b_bad   = ~rd_b_sel[5] & ({1'b0, rd_b_sel[4:0]} >= GPR_LIMIT);
  assign wr_spec = wr_en & wr_sel[5];

  always_comb begin
    rd_a_data = '0;
    if (rd_a_sel[5]) begin
      case (rd_a_sel[1:0])
        2'd0:    rd_a_data = reg_rg;
        2'd1:    rd_a_data = reg_rd;
        2'd2:    rd_a_data = reg_pc;
        default: rd_a_data = reg_flag;
      endcase
    end else if (!a_bad) begin
      rd_a_data = gpr[rd_a_sel[4:0]];
    end
  end

  always_comb begin
    rd_b_data = '0;
    if (rd_b_sel[5]) begin
      case (rd_b_sel[1:0])
        2'd0:    rd_b_data = reg_rg;
        2'd1:    rd_b_data = reg_rd;
        2'd2:    rd_b_data = reg_pc;
        default: rd_b_data = reg_flag;
      endcase
    end else if (!b_bad) begin
      rd_b_data = gpr[rd_b_sel[4:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
    end else if (wr_en && !wr_sel[5] && !wr_bad) begin
      for (int i = 0; i < NUM_GPR; i++)
        if (wr_sel[4:0] == 5'(i)) gpr[i] <= wr_data;
    end
  end

  always_comb begin
    flag_nx = reg_flag;
    if (wr_spec && wr_sel[1:0] == 2'd3) flag_nx = wr_data;
    flag_nx[3:0] = (flag_nx[3:0] & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rg   <= '0;
      reg_rd   <= '0;
      reg_pc   <= '0;
      reg_flag <= '0;
    end else begin
      if (wr_spec && wr_sel[1:0] == 2'd0) reg_rg <= wr_data;
      if (wr_spec && wr_sel[1:0] == 2'd1) reg_rd <= wr_data;
      if (wr_spec && wr_sel[1:0] == 2'd2) reg_pc <= wr_data;
      reg_flag <= flag_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_INIT;
    else if (sp_we) sp_q <= sp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (wr_en & wr_bad) | (rd_a_en & a_bad) | (rd_b_en & b_bad);
  end

  assign flag_ovf  = reg_flag[0];
  assign flag_zero = reg_flag[1];
  assign flag_sign = reg_flag[2];
  assign flag_par  = reg_flag[3];

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R3
  bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && wr_bad) || (rd_a_en && a_bad) || (rd_b_en && b_bad)) |=> err_q);

  // R3
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_bad |-> rd_a_data == '0);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((reg_flag[3:0] & $past(flag_set)) == $past(flag_set)));

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_clr & ~flag_set)) |=> ((reg_flag[3:0] & $past(flag_clr & ~flag_set)) == 4'd0));

  // R2
  spec_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_spec && wr_sel[1:0] == 2'd0 && !sp_we) |=> ($stable(reg_rd) && $stable(reg_pc) && $stable(sp_q)));

  // R8
  sp_init_chk: assert property (@(posedge clk)
    !rst_n |=> sp_q == SP_INIT);

endmodule

// File: tb/regbank_spec_tb.sv
`timescale 1ns/1ps
module regbank_spec_tb;
  localparam int NGPR = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_a_en = 0, rd_b_en = 0, sp_we = 0;
  logic [5:0] wr_sel = 0, rd_a_sel = 0, rd_b_sel = 0;
  logic [31:0] wr_data = 0, sp_wdata = 0;
  logic [3:0] flag_set = 0, flag_clr = 0;
  logic [31:0] rd_a_data, rd_b_data, sp_q;
  logic flag_ovf, flag_zero, flag_sign, flag_par, err_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regbank_spec #(.DATA_W(32), .NUM_GPR(NGPR), .MEM_WORDS(1024)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_a_en(rd_a_en), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .flag_set(flag_set), .flag_clr(flag_clr), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .sp_q(sp_q), .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_par(flag_par), .err_q(err_q));

  // {write sel, write data, read sel, expected}
  localparam logic [75:0] VEC [10] = '{
    {6'h00, 32'h11111111, 6'h00, 32'h11111111},
    {6'd23, 32'hA5A5A5A5, 6'd23, 32'hA5A5A5A5},
    {6'h20, 32'hCAFE0001, 6'h20, 32'hCAFE0001},
    {6'h21, 32'hBEEF0002, 6'h21, 32'hBEEF0002},
    {6'h22, 32'h00000100, 6'h22, 32'h00000100},
    {6'h23, 32'h0000000F, 6'h23, 32'h0000000F},
    {6'h3C, 32'h12345678, 6'h20, 32'h12345678},
    {6'h05, 32'h00000005, 6'h00, 32'h11111111},
    {6'h20, 32'h00000000, 6'h21, 32'hBEEF0002},
    {6'd24, 32'hFFFFFFFF, 6'd24, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [5:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(input logic [3:0] s, input logic [3:0] c);
    @(negedge clk); flag_set = s; flag_clr = c;
    @(negedge clk); flag_set = 0; flag_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    // R10 and R8 reset state
    rd_a_sel = 6'h00; #0.1 chk("R10 gpr0", rd_a_data, 0);
    rd_a_sel = 6'h20; #0.1 chk("R10 Rg", rd_a_data, 0);
    rd_a_sel = 6'h23; #0.1 chk("R10 flags", rd_a_data, 0);
    chk("R8 sp reset", sp_q, 32'd1023);
    chk("R4 err reset", {31'd0, err_q}, 0);

    // R1 R2 R3 vector table
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      wr_en = 1; wr_sel = VEC[i][75:70]; wr_data = VEC[i][69:38];
      rd_a_en = 1; rd_a_sel = VEC[i][37:32];
      @(negedge clk);
      wr_en = 0; #1;
      chk(i < 2 ? "R1 table" : (i < 9 ? "R2 table" : "R3 table"), rd_a_data, VEC[i][31:0]);
    end
    rd_a_en = 0;

    // R3 error raised, earlier register untouched by invalid write (port B)
    #0.5 chk("R3 err set", {31'd0, err_q}, 1);
    rd_b_sel = 6'h00; #0.1 chk("R3 gpr0 intact", rd_b_data, 32'h11111111);
    rd_b_sel = 6'h21; #0.1 chk("R2 Rd via port B", rd_b_data, 32'hBEEF0002);

    // R4 sticky
    repeat (4) @(negedge clk);
    #1 chk("R4 err holds", {31'd0, err_q}, 1);
    do_reset(); #1;
    chk("R4 err cleared by reset", {31'd0, err_q}, 0);
    rd_a_sel = 6'd23; #0.1 chk("R10 gpr23 cleared", rd_a_data, 0);

    // R3 invalid write alone: no alias onto reg 6, error set
    wr(6'd6, 32'h66);
    wr(6'd30, 32'hDEADDEAD); #1;
    rd_a_sel = 6'd6; #0.1 chk("R3 no alias", rd_a_data, 32'h66);
    chk("R3 err on write", {31'd0, err_q}, 1);
    rd_b_en = 1; rd_b_sel = 6'd31; #0.1 chk("R3 read zero port B", rd_b_data, 0);
    rd_b_en = 0;

    // R9 read during write
    @(negedge clk); wr_en = 1; wr_sel = 6'd6; wr_data = 32'h77; rd_a_sel = 6'd6;
    #1 chk("R9 old value", rd_a_data, 32'h66);
    @(negedge clk); wr_en = 0; #1;
    chk("R9 new value", rd_a_data, 32'h77);

    // R6 R7 R5 flags
    rd_a_sel = 6'h23;
    wr(6'h23, 32'hF0);
    strobe(4'b0100, 4'b0000); #1 chk("R6 set sign", rd_a_data, 32'hF4);
    strobe(4'b0001, 4'b0100); #1 chk("R6 set ovf clr sign", rd_a_data, 32'hF1);
    strobe(4'b0010, 4'b0010); #1 chk("R6 set wins", rd_a_data, 32'hF3);
    @(negedge clk); wr_en = 1; wr_sel = 6'h23; wr_data = 32'h8; flag_set = 4'b0001; flag_clr = 4'b1000;
    @(negedge clk); wr_en = 0; flag_set = 0; flag_clr = 0; #1;
    chk("R7 write plus strobes", rd_a_data, 32'h1);
    chk("R5 decoded 0x1", {28'd0, flag_par, flag_sign, flag_zero, flag_ovf}, 32'h1);
    strobe(4'b0110, 4'b0000); #1;
    chk("R5 decoded 0x7", {28'd0, flag_par, flag_sign, flag_zero, flag_ovf}, 32'h7);
    strobe(4'b1000, 4'b0011); #1;
    chk("R5 decoded 0xC", {28'd0, flag_par, flag_sign, flag_zero, flag_ovf}, 32'hC);

    // R8 stack pointer load and reset
    @(negedge clk); sp_we = 1; sp_wdata = 32'h200;
    @(negedge clk); sp_we = 0; #1;
    chk("R8 sp load", sp_q, 32'h200);
    do_reset(); #1;
    chk("R8 sp back to top", sp_q, 32'd1023);

    finish_run();
  end
endmodule